// File: doc/BRIEF.md
# Memory-Class Execution Unit

This unit executes the memory instructions of a 32-bit out-of-order core: a word load, a word store, two immediate-to-register forms and two immediate-to-memory forms. An issued operation arrives with its operation ID, a 3-bit opcode, two register indices (the destination-field index `rd` and the source-field index `rs`) and a 16-bit immediate. In the cycle of issue the unit reads both registers through a register-read port. That port is tagged with the operation ID, so the reorder buffer behind it can forward values from older operations that are still in flight.

A second stage computes the final record. For a load it drives a load port whose owner forwards any pending store to the same word and otherwise returns memory contents. The finished record goes to a one-entry output slot under a valid/ready handshake. It is either a register write (kind 0, destination = register index) or a memory write (kind 1, destination = byte address), and it carries the 32-bit value and the operation ID. An opcode outside the six defined ones produces no record. Instead it raises a one-cycle error pulse that carries the operation ID.

Top module: `memop_exec_unit`

## Requirements
- R1: Opcode 0 (word load) drives the load port with address `reg[rs] + zext(imm)` and emits a kind-0 record whose value is the word the load port returns.
- R2: Opcode 1 (word store) emits a kind-1 record with destination `reg[rd] + zext(imm)` and value `reg[rs]`.
- R3: Opcode 2 (lower immediate to register) emits a kind-0 record with value `zext(imm)` and never raises the load-port valid.
- R4: Opcode 3 (lower immediate to memory) emits a kind-1 record with destination `reg[rd]`, with no offset added, and value `zext(imm)`.
- R5: Opcode 4 (upper immediate to register) emits a kind-0 record with value `imm << 16`, so the low half is zero.
- R6: Opcode 5 (upper immediate to memory) emits a kind-1 record with destination `reg[rd]` and value `imm << 16`.
- R7: Opcodes 6 and 7 emit no record. They pulse `err_valid` for one cycle, two clock edges after acceptance, with `err_op_id` equal to the operation ID. This holds even while the output slot is stalled.
- R8: Every record carries the operation ID it was issued with. A kind-0 record's destination is `rd` zero-extended to 32 bits.
- R9: A record becomes valid two clock edges after its acceptance. While `out_ready` is low it stays valid with all fields unchanged.
- R10: When both internal stages are occupied and the output is stalled, `in_ready` is low. Records leave in issue order, with none lost and none duplicated.
- R11: After reset, `out_valid`, `err_valid` and `ld_valid` are low and `in_ready` is high.
- R12: In the issue cycle the register-read port presents `rd` on port A and `rs` on port B, both tagged with the issuing operation ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issued operation present |
| in_ready | output | 1 | Unit accepts the operation this cycle |
| in_op_id | input | ID_W | Operation ID |
| in_opcode | input | 3 | Memory-class opcode |
| in_rd_idx | input | REG_W | Destination-field register index |
| in_rs_idx | input | REG_W | Source-field register index |
| in_imm | input | IMM_W | Immediate field |
| rp_op_id | output | ID_W | Tag for register forwarding |
| rp_a_idx | output | REG_W | Register index read on port A |
| rp_a_data | input | DATA_W | Value of port A register |
| rp_b_idx | output | REG_W | Register index read on port B |
| rp_b_data | input | DATA_W | Value of port B register |
| ld_valid | output | 1 | Load request present |
| ld_addr | output | DATA_W | Load byte address |
| ld_op_id | output | ID_W | Tag for store-to-load forwarding |
| ld_data | input | DATA_W | Loaded word, same cycle |
| out_valid | output | 1 | Result record present |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 1 | 0 register write, 1 memory write |
| out_dest | output | DATA_W | Register index or byte address |
| out_value | output | DATA_W | Value to write |
| out_op_id | output | ID_W | Operation ID of the record |
| err_valid | output | 1 | Illegal opcode report |
| err_op_id | output | ID_W | Operation ID of the illegal operation |

## Verification
The bench builds the unit with `REG_W = 3` and `ID_W = 4`, keeping the 32-bit data path. This makes it practical to sweep all eight opcodes against every pairing of the eight `rd` and eight `rs` indices, under four immediates that include zero, all ones and the top bit alone. It models the register port and the load port as arithmetic functions of index, tag and address, so each expected destination and value is recomputed independently, including offset carries and the 16-bit shift. Directed sequences stall the output to fill both stages, inject an illegal opcode behind a stalled record, and release the stall to confirm order and the absence of duplicates.

// File: rtl/memop_pkg.sv
// Package: shared opcode encoding and decoded control for the memory-class
// execution unit. Assumes a 3-bit opcode field supplied by the issue logic.
package memop_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_LD_WORD  = 3'd0,
        OPC_ST_WORD  = 3'd1,
        OPC_LD_LOIMM = 3'd2,
        OPC_ST_LOIMM = 3'd3,
        OPC_LD_UPIMM = 3'd4,
        OPC_ST_UPIMM = 3'd5
    } opcode_e;

    typedef enum logic [1:0] {
        VAL_SRC_REG = 2'd0,
        VAL_IMM_LO  = 2'd1,
        VAL_IMM_HI  = 2'd2,
        VAL_MEMORY  = 2'd3
    } val_sel_e;

    typedef enum logic {
        REC_REG = 1'b0,
        REC_MEM = 1'b1
    } rec_kind_e;

    typedef struct packed {
        logic      illegal;
        rec_kind_e kind;
        logic      base_is_rd;
        logic      add_offset;
        logic      is_load;
        val_sel_e  val_sel;
    } ctrl_t;

endpackage

// File: rtl/memop_decode.sv
// Module: memop_decode
// Turns the opcode into control fields for address and value formation.
// Assumes opcodes 6 and 7 are unassigned and must be reported as illegal.
module memop_decode
    import memop_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    // Purpose: map each defined opcode to its record kind, base and value source.
    always_comb begin
        ctrl            = '0;
        ctrl.kind       = REC_REG;
        ctrl.val_sel    = VAL_SRC_REG;
        case (opcode)
            OPC_LD_WORD: begin
                ctrl.is_load    = 1'b1;
                ctrl.add_offset = 1'b1;
                ctrl.base_is_rd = 1'b0;
                ctrl.val_sel    = VAL_MEMORY;
            end
            OPC_ST_WORD: begin
                ctrl.kind       = REC_MEM;
                ctrl.add_offset = 1'b1;
                ctrl.base_is_rd = 1'b1;
                ctrl.val_sel    = VAL_SRC_REG;
            end
            OPC_LD_LOIMM: begin
                ctrl.val_sel    = VAL_IMM_LO;
            end
            OPC_ST_LOIMM: begin
                ctrl.kind       = REC_MEM;
                ctrl.base_is_rd = 1'b1;
                ctrl.val_sel    = VAL_IMM_LO;
            end
            OPC_LD_UPIMM: begin
                ctrl.val_sel    = VAL_IMM_HI;
            end
            OPC_ST_UPIMM: begin
                ctrl.kind       = REC_MEM;
                ctrl.base_is_rd = 1'b1;
                ctrl.val_sel    = VAL_IMM_HI;
            end
            default: begin
                ctrl.illegal    = 1'b1;
            end
        endcase
    end

    // Purpose: a decoded load never targets memory as its record kind.
    always_comb begin
        AST_LOAD_IS_REG_KIND: assert (!(ctrl.is_load && ctrl.kind == REC_MEM)); // R1
    end

endmodule

// File: rtl/memop_agen.sv
// Module: memop_agen
// Forms the byte address, the record destination and the immediate-derived
// value for one operation. Assumes register values are already forwarded.
// Immediates are zero-extended; the upper form shifts by half the data width.
module memop_agen
    import memop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int REG_W  = 5
) (
    input  rec_kind_e         kind,
    input  logic              base_is_rd,
    input  logic              add_offset,
    input  val_sel_e          val_sel,
    input  logic [REG_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] dest,
    output logic [DATA_W-1:0] value
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] imm_lo;
    logic [DATA_W-1:0] imm_hi;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] offset;

    // Purpose: widen the immediate in its lower and upper placements.
    always_comb begin
        imm_lo = DATA_W'(imm);
        imm_hi = imm_lo << HALF_W;
    end

    // Purpose: pick the base register and add the offset when the form has one.
    always_comb begin
        base   = base_is_rd ? rd_val : rs_val;
        offset = add_offset ? imm_lo : '0;
        addr   = base + offset;
    end

    // Purpose: choose the record destination, register index or address.
    always_comb begin
        if (kind == REC_MEM) begin
            dest = addr;
        end else begin
            dest = DATA_W'(rd_idx);
        end
    end

    // Purpose: choose the value carried forward; memory data is merged later.
    always_comb begin
        case (val_sel)
            VAL_SRC_REG: value = rs_val;
            VAL_IMM_LO:  value = imm_lo;
            VAL_IMM_HI:  value = imm_hi;
            default:     value = '0;
        endcase
    end

endmodule

// File: rtl/memop_stage.sv
// Module: memop_stage
// Holds one operation in the load stage, drives the load port, and keeps a
// one-entry output slot under valid/ready. Illegal operations bypass the
// slot and leave as a one-cycle error pulse. Assumes ld_data answers in the
// same cycle as ld_addr.
module memop_stage
    import memop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    output logic              acc_ready,
    input  logic              acc_illegal,
    input  logic              acc_load,
    input  rec_kind_e         acc_kind,
    input  logic [DATA_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_dest,
    input  logic [DATA_W-1:0] acc_value,
    input  logic [ID_W-1:0]   acc_id,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_addr,
    output logic [ID_W-1:0]   ld_op_id,
    input  logic [DATA_W-1:0] ld_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_kind,
    output logic [DATA_W-1:0] out_dest,
    output logic [DATA_W-1:0] out_value,
    output logic [ID_W-1:0]   out_op_id,
    output logic              err_valid,
    output logic [ID_W-1:0]   err_op_id
);

    logic              b_valid;
    logic              b_illegal;
    logic              b_load;
    rec_kind_e         b_kind;
    logic [DATA_W-1:0] b_addr;
    logic [DATA_W-1:0] b_dest;
    logic [DATA_W-1:0] b_value;
    logic [ID_W-1:0]   b_id;

    logic              o_valid;
    rec_kind_e         o_kind;
    logic [DATA_W-1:0] o_dest;
    logic [DATA_W-1:0] o_value;
    logic [ID_W-1:0]   o_id;

    logic              e_valid;
    logic [ID_W-1:0]   e_id;

    logic              slot_free;
    logic              b_advance;
    logic [DATA_W-1:0] b_final;

    // Purpose: decide whether the held operation leaves the stage this cycle.
    always_comb begin
        slot_free = !o_valid || out_ready;
        b_advance = b_valid && (b_illegal || slot_free);
        acc_ready = !b_valid || b_advance;
        b_final   = b_load ? ld_data : b_value;
    end

    // Purpose: present the load request for a held load.
    always_comb begin
        ld_valid = b_valid && b_load;
        ld_addr  = b_addr;
        ld_op_id = b_id;
    end

    // Purpose: capture an accepted operation into the load stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid   <= 1'b0;
            b_illegal <= 1'b0;
            b_load    <= 1'b0;
            b_kind    <= REC_REG;
            b_addr    <= '0;
            b_dest    <= '0;
            b_value   <= '0;
            b_id      <= '0;
        end else if (acc_fire) begin
            b_valid   <= 1'b1;
            b_illegal <= acc_illegal;
            b_load    <= acc_load;
            b_kind    <= acc_kind;
            b_addr    <= acc_addr;
            b_dest    <= acc_dest;
            b_value   <= acc_value;
            b_id      <= acc_id;
        end else if (b_advance) begin
            b_valid   <= 1'b0;
        end
    end

    // Purpose: fill or drain the output slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_kind  <= REC_REG;
            o_dest  <= '0;
            o_value <= '0;
            o_id    <= '0;
        end else if (b_advance && !b_illegal) begin
            o_valid <= 1'b1;
            o_kind  <= b_kind;
            o_dest  <= b_dest;
            o_value <= b_final;
            o_id    <= b_id;
        end else if (out_ready) begin
            o_valid <= 1'b0;
        end
    end

    // Purpose: report an illegal operation for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 1'b0;
            e_id    <= '0;
        end else begin
            e_valid <= b_advance && b_illegal;
            e_id    <= b_id;
        end
    end

    // Purpose: drive the record and error outputs from their registers.
    always_comb begin
        out_valid = o_valid;
        out_kind  = o_kind;
        out_dest  = o_dest;
        out_value = o_value;
        out_op_id = o_id;
        err_valid = e_valid;
        err_op_id = e_id;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_dest) && $stable(out_value)
            && $stable(out_op_id) && $stable(out_kind)); // R9

    AST_JAM_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && !b_illegal && out_valid && !out_ready |-> !acc_ready); // R10

    AST_ERR_NOT_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !$rose(out_valid)); // R7

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid || (err_op_id != $past(err_op_id)) || $past(acc_fire, 2)); // R7

endmodule

// File: rtl/memop_exec_unit.sv
// Module: memop_exec_unit
// Top of the memory-class execution unit: decodes the opcode, reads both
// registers through the forwarding read port in the issue cycle, forms
// address and value, then completes loads and emits tagged records.
// Assumes the read port and the load port answer combinationally.
module memop_exec_unit
    import memop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int REG_W  = 5,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ID_W-1:0]   in_op_id,
    input  logic [2:0]        in_opcode,
    input  logic [REG_W-1:0]  in_rd_idx,
    input  logic [REG_W-1:0]  in_rs_idx,
    input  logic [IMM_W-1:0]  in_imm,
    output logic [ID_W-1:0]   rp_op_id,
    output logic [REG_W-1:0]  rp_a_idx,
    input  logic [DATA_W-1:0] rp_a_data,
    output logic [REG_W-1:0]  rp_b_idx,
    input  logic [DATA_W-1:0] rp_b_data,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_addr,
    output logic [ID_W-1:0]   ld_op_id,
    input  logic [DATA_W-1:0] ld_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_kind,
    output logic [DATA_W-1:0] out_dest,
    output logic [DATA_W-1:0] out_value,
    output logic [ID_W-1:0]   out_op_id,
    output logic              err_valid,
    output logic [ID_W-1:0]   err_op_id
);

    ctrl_t             ctrl;
    logic              acc_fire;
    logic              acc_ready;
    logic [DATA_W-1:0] f_addr;
    logic [DATA_W-1:0] f_dest;
    logic [DATA_W-1:0] f_value;

    // Purpose: present both register indices with the issuing tag.
    always_comb begin
        rp_op_id = in_op_id;
        rp_a_idx = in_rd_idx;
        rp_b_idx = in_rs_idx;
        in_ready = acc_ready;
        acc_fire = in_valid && acc_ready;
    end

    memop_decode u_decode (
        .opcode (in_opcode),
        .ctrl   (ctrl)
    );

    memop_agen #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .REG_W  (REG_W)
    ) u_agen (
        .kind       (ctrl.kind),
        .base_is_rd (ctrl.base_is_rd),
        .add_offset (ctrl.add_offset),
        .val_sel    (ctrl.val_sel),
        .rd_idx     (in_rd_idx),
        .rd_val     (rp_a_data),
        .rs_val     (rp_b_data),
        .imm        (in_imm),
        .addr       (f_addr),
        .dest       (f_dest),
        .value      (f_value)
    );

    memop_stage #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_fire    (acc_fire),
        .acc_ready   (acc_ready),
        .acc_illegal (ctrl.illegal),
        .acc_load    (ctrl.is_load),
        .acc_kind    (ctrl.kind),
        .acc_addr    (f_addr),
        .acc_dest    (f_dest),
        .acc_value   (f_value),
        .acc_id      (in_op_id),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_op_id    (ld_op_id),
        .ld_data     (ld_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_kind    (out_kind),
        .out_dest    (out_dest),
        .out_value   (out_value),
        .out_op_id   (out_op_id),
        .err_valid   (err_valid),
        .err_op_id   (err_op_id)
    );

    AST_ILLEGAL_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_opcode > 3'd5 |-> ##2 (err_valid && err_op_id == $past(in_op_id, 2))); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !err_valid && !ld_valid && in_ready); // R11

    AST_REG_DEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_kind |-> out_dest < DATA_W'(2 ** REG_W)); // R8

    AST_LOAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_opcode == 3'd0 |=> ld_valid && ld_op_id == $past(in_op_id)); // R1

endmodule

// File: tb/memop_exec_unit_test.sv
// Bench: sweeps opcodes, register indices and immediates on a small build,
// with register and memory contents modelled as arithmetic functions.
module memop_exec_unit_test;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int REG_W  = 3;
    localparam int ID_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ID_W-1:0]   in_op_id = '0;
    logic [2:0]        in_opcode = '0;
    logic [REG_W-1:0]  in_rd_idx = '0;
    logic [REG_W-1:0]  in_rs_idx = '0;
    logic [IMM_W-1:0]  in_imm = '0;
    logic [ID_W-1:0]   rp_op_id;
    logic [REG_W-1:0]  rp_a_idx;
    logic [DATA_W-1:0] rp_a_data;
    logic [REG_W-1:0]  rp_b_idx;
    logic [DATA_W-1:0] rp_b_data;
    logic              ld_valid;
    logic [DATA_W-1:0] ld_addr;
    logic [ID_W-1:0]   ld_op_id;
    logic [DATA_W-1:0] ld_data;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic              out_kind;
    logic [DATA_W-1:0] out_dest;
    logic [DATA_W-1:0] out_value;
    logic [ID_W-1:0]   out_op_id;
    logic              err_valid;
    logic [ID_W-1:0]   err_op_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] regv(input logic [REG_W-1:0] idx, input logic [ID_W-1:0] id);
        return 32'hA500_0000 ^ (32'(idx) * 32'h0101_0111) ^ (32'(id) << 20);
    endfunction

    function automatic logic [31:0] memv(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h3C3C_C3C3;
    endfunction

    assign rp_a_data = regv(rp_a_idx, rp_op_id);
    assign rp_b_data = regv(rp_b_idx, rp_op_id);
    assign ld_data   = memv(ld_addr);

    memop_exec_unit #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .REG_W  (REG_W),
        .ID_W   (ID_W)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_op_id (in_op_id),
        .in_opcode (in_opcode), .in_rd_idx (in_rd_idx), .in_rs_idx (in_rs_idx),
        .in_imm (in_imm),
        .rp_op_id (rp_op_id), .rp_a_idx (rp_a_idx), .rp_a_data (rp_a_data),
        .rp_b_idx (rp_b_idx), .rp_b_data (rp_b_data),
        .ld_valid (ld_valid), .ld_addr (ld_addr), .ld_op_id (ld_op_id), .ld_data (ld_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_kind (out_kind),
        .out_dest (out_dest), .out_value (out_value), .out_op_id (out_op_id),
        .err_valid (err_valid), .err_op_id (err_op_id)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One operation through an otherwise idle pipeline, checked at every stage.
    task automatic run_one(input logic [2:0] opc, input logic [REG_W-1:0] rd,
                           input logic [REG_W-1:0] rs, input logic [IMM_W-1:0] imm,
                           input logic [ID_W-1:0] id);
        logic [31:0] lo, hi, rdv, rsv, e_dest, e_val, e_ld;
        logic e_kind, e_err, e_load;
        string tag;
        lo  = 32'(imm);
        hi  = lo << 16;
        rdv = regv(rd, id);
        rsv = regv(rs, id);
        e_err = 1'b0; e_load = 1'b0; e_kind = 1'b0; e_dest = 32'(rd); e_val = '0; e_ld = '0;
        case (opc)
            3'd0: begin tag = "R1"; e_load = 1'b1; e_ld = rsv + lo; e_val = memv(rsv + lo); end
            3'd1: begin tag = "R2"; e_kind = 1'b1; e_dest = rdv + lo; e_val = rsv; end
            3'd2: begin tag = "R3"; e_val = lo; end
            3'd3: begin tag = "R4"; e_kind = 1'b1; e_dest = rdv; e_val = lo; end
            3'd4: begin tag = "R5"; e_val = hi; end
            3'd5: begin tag = "R6"; e_kind = 1'b1; e_dest = rdv; e_val = hi; end
            default: begin tag = "R7"; e_err = 1'b1; end
        endcase
        in_valid = 1'b1; in_opcode = opc; in_rd_idx = rd; in_rs_idx = rs; in_imm = imm; in_op_id = id;
        #1;
        chk(in_ready, "R10 in_ready idle", 32'(in_ready), 1);
        chk(rp_a_idx == rd && rp_b_idx == rs && rp_op_id == id, "R12 read port",
            {rp_op_id, 8'h0, 5'(rp_a_idx), 5'(rp_b_idx)}, {id, 8'h0, 5'(rd), 5'(rs)});
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (e_load) begin
            chk(ld_valid && ld_addr == e_ld && ld_op_id == id, "R1 load address", ld_addr, e_ld);
        end else begin
            chk(!ld_valid, {tag, " no load request"}, 32'(ld_valid), 0);
        end
        @(posedge clk);
        @(negedge clk);
        if (e_err) begin
            chk(err_valid && err_op_id == id && !out_valid, "R7 illegal reported",
                {err_op_id, 3'b0, out_valid, 23'b0, err_valid}, {id, 27'b1});
        end else begin
            chk(out_valid && !err_valid, {tag, " R9 record valid"}, 32'(out_valid), 1);
            chk(out_kind == e_kind, {tag, " kind"}, 32'(out_kind), 32'(e_kind));
            chk(out_dest == e_dest, {tag, " R8 dest"}, out_dest, e_dest);
            chk(out_value == e_val, {tag, " value"}, out_value, e_val);
            chk(out_op_id == id, "R8 op id", 32'(out_op_id), 32'(id));
        end
    endtask

    task automatic issue_at_negedge(input logic [2:0] opc, input logic [IMM_W-1:0] imm,
                                    input logic [ID_W-1:0] id);
        in_valid = 1'b1; in_opcode = opc; in_rd_idx = 3'd1; in_rs_idx = 3'd2; in_imm = imm; in_op_id = id;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'(checks), 32'(0));
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !err_valid && !ld_valid && in_ready, "R11 reset state",
            {28'b0, out_valid, err_valid, ld_valid, in_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every opcode and register pair under four immediates.
        begin
            logic [IMM_W-1:0] imms [4];
            logic [ID_W-1:0] id;
            imms[0] = 16'h0000; imms[1] = 16'hFFFF; imms[2] = 16'h8000; imms[3] = 16'h1234;
            id = '0;
            for (int o = 0; o < 8; o++)
                for (int d = 0; d < 8; d++)
                    for (int s = 0; s < 8; s++)
                        for (int k = 0; k < 4; k++) begin
                            run_one(3'(o), 3'(d), 3'(s), imms[k], id);
                            id = id + 1'b1;
                        end
        end
        @(negedge clk);
        chk(!out_valid && !err_valid, "R9 slot drained", {31'b0, out_valid}, 0);

        // Backpressure: fill both stages, then release.
        out_ready = 1'b0;
        issue_at_negedge(3'd2, 16'h0011, 4'd1);
        @(posedge clk); @(negedge clk);
        issue_at_negedge(3'd2, 16'h0022, 4'd2);
        chk(in_ready, "R10 second stage free", 32'(in_ready), 1);
        @(posedge clk); @(negedge clk);
        issue_at_negedge(3'd4, 16'h0033, 4'd3);
        chk(out_valid && out_op_id == 4'd1 && out_value == 32'h11, "R9 first record", out_value, 32'h11);
        chk(!in_ready, "R10 jammed", 32'(in_ready), 0);
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk(out_valid && out_op_id == 4'd1 && out_value == 32'h11 && !out_kind,
                "R9 record held", {out_op_id, out_value[27:0]}, {4'd1, 28'h11});
            chk(!in_ready, "R10 still jammed", 32'(in_ready), 0);
        end
        out_ready = 1'b1;
        #1;
        chk(in_ready, "R10 release opens input", 32'(in_ready), 1);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_op_id == 4'd2 && out_value == 32'h22, "R10 second in order", out_value, 32'h22);
        @(posedge clk); @(negedge clk);
        chk(out_valid && out_op_id == 4'd3 && out_value == 32'h0033_0000, "R10 third in order",
            out_value, 32'h0033_0000);
        @(posedge clk); @(negedge clk);
        chk(!out_valid, "R10 no duplicate", 32'(out_valid), 0);

        // Illegal opcode behind a stalled record.
        out_ready = 1'b0;
        issue_at_negedge(3'd3, 16'h0044, 4'd5);
        @(posedge clk); @(negedge clk);
        issue_at_negedge(3'd7, 16'h0000, 4'd9);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk(!err_valid && out_valid && out_op_id == 4'd5, "R7 stall precedes error", 32'(err_valid), 0);
        @(posedge clk); @(negedge clk);
        chk(err_valid && err_op_id == 4'd9, "R7 error while stalled", 32'(err_op_id), 32'd9);
        chk(out_valid && out_op_id == 4'd5 && out_dest == regv(3'd1, 4'd5), "R4 record kept",
            out_dest, regv(3'd1, 4'd5));
        @(posedge clk); @(negedge clk);
        chk(!err_valid, "R7 single pulse", 32'(err_valid), 0);
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!out_valid, "R7 no record for illegal", 32'(out_valid), 0);

        finish_run();
    end

endmodule